// File: doc/BRIEF.md
# Port Power-Good and Zero-Current Disconnect Monitor

This block watches a powered port after its switch has been turned on. It decides when the port output is good, and when the load has gone away. Three comparator results come in as synchronous flags:

- the output is close to the input rail;
- the output has sagged away from the input rail;
- the load current is under the zero-current threshold.

All timing is counted on a timebase tick of 100 µs. The power-good flag waits a long qualification interval before it rises and a short one before it falls.

Once power-good is up and zero-current monitoring is enabled, the block times continuous undercurrent. When that timer runs out, the block latches the active-low zero-current flag and pulses a disconnect request. That request switches the port off and starts a new detection pass.

How the latch is released depends on the detection setting. With detection enabled, the next successful detection releases it. With detection disabled, only pulling the port enable low releases it. Undercurrent episodes are filtered: an above-threshold stretch shorter than the deglitch window is ignored and the timer keeps running through it. A stretch as long as the window restarts the timer from zero.

Top module: `zcpg_monitor`

## Requirements
- R1: `pgood` rises on the edge that samples the PG_ON_TICKS-th consecutive tick with `near_in` high; a tick with `near_in` low restarts that count from zero.
- R2: `pgood` falls on the edge that samples the PG_OFF_TICKS-th consecutive tick with `out_drop` high; a shorter run of `out_drop` leaves `pgood` high.
- R3: Zero-current timing runs only while `en`, `zc_en` and `pgood` are high and no fault is latched; with `zc_en` low, any length of undercurrent leaves `zc_n` high and `disc_req` low.
- R4: While armed, `zc_n` goes low on the edge that samples the TRIP_TICKS-th tick of an undercurrent interval, counted from its first tick with `under_i` high.
- R5: Ticks with `under_i` low inside an interval still advance the interval timer. GLITCH_TICKS consecutive such ticks end the interval and zero the timer.
- R6: `disc_req` is high for exactly one clock, on the same edge where `zc_n` falls.
- R7: With `det_off` low, a `det_ok` pulse releases a latched fault, so `zc_n` is high after the next edge.
- R8: With `det_off` high, `det_ok` has no effect on a latched fault. `en` low releases it on the next edge.
- R9: When `pgood` clears, both undercurrent timers return to zero, so after `pgood` returns a full TRIP_TICKS interval is needed again.
- R10: After reset `pgood` is 0, `zc_n` is 1 and `disc_req` is 0. Without a `tick`, no timer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase strobe (100 µs by default) |
| en | input | 1 | Port enable; low releases a latched fault |
| near_in | input | 1 | Output within the good-band of the input rail |
| out_drop | input | 1 | Output has sagged out of the good-band |
| under_i | input | 1 | Load current below zero-current threshold |
| zc_en | input | 1 | Zero-current monitoring enable |
| det_off | input | 1 | Detection disabled for this port |
| det_ok | input | 1 | One-clock pulse: detection succeeded |
| pgood | output | 1 | Power-good flag |
| zc_n | output | 1 | Zero-current fault flag, active low, latched |
| disc_req | output | 1 | One-clock request to switch off and re-detect |

## Verification
If the power-good counter is corrupted, `pgood` changes edge at the wrong time. That shows at the port within one qualification window: at most PG_ON_TICKS ticks for a rise, PG_OFF_TICKS ticks for a fall.

A fault in the undercurrent timer or the deglitch counter moves the falling edge of `zc_n` and `disc_req` by one or more ticks. Runs that stop exactly one tick short of each limit expose that error within a single TRIP_TICKS interval.

A latch that fails to release, or releases on the wrong source, shows at `zc_n` one edge after `det_ok` or `en`.

// File: rtl/zcpg_pkg.sv
package zcpg_pkg;
  // Source that may clear a latched zero-current fault.
  typedef enum logic [1:0] {
    REL_HOLD   = 2'd0,
    REL_DETECT = 2'd1,
    REL_ENABLE = 2'd2
  } rel_src_t;
endpackage

// File: rtl/zcpg_pg_filter.sv
module zcpg_pg_filter #(
  parameter int ON_TICKS  = 880,
  parameter int OFF_TICKS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic near_in,
  input  logic out_drop,
  output logic pgood
);
  localparam int MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          cond;
  logic [CW-1:0] last;

  // Qualifying condition depends on the present state of the flag.
  always_comb begin
    cond = pgood ? out_drop : near_in;
    last = pgood ? OFF_LAST : ON_LAST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pgood <= 1'b0;
    end else if (tick) begin
      if (!cond) begin
        cnt <= '0;
      end else if (cnt == last) begin
        cnt   <= '0;
        pgood <= ~pgood;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zcpg_uc_timer.sv
module zcpg_uc_timer #(
  parameter int TRIP_TICKS   = 3500,
  parameter int GLITCH_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic under_i,
  output logic expire
);
  localparam int TW = $clog2(TRIP_TICKS + 1);
  localparam int GW = $clog2(GLITCH_TICKS + 1);
  localparam logic [TW-1:0] TRIP_LAST = TW'(TRIP_TICKS - 1);
  localparam logic [GW-1:0] GL_LAST   = GW'(GLITCH_TICKS - 1);

  logic [TW-1:0] uc_cnt, uc_nxt;
  logic [GW-1:0] ok_cnt, ok_nxt;

  always_comb begin
    uc_nxt = uc_cnt;
    ok_nxt = ok_cnt;
    expire = 1'b0;
    if (!armed) begin
      uc_nxt = '0;
      ok_nxt = '0;
    end else if (tick) begin
      if (under_i) begin
        ok_nxt = '0;
        if (uc_cnt == TRIP_LAST) begin
          expire = 1'b1;
          uc_nxt = '0;
        end else begin
          uc_nxt = uc_cnt + 1'b1;
        end
      end else if (uc_cnt != '0) begin
        if (ok_cnt == GL_LAST) begin
          uc_nxt = '0;
          ok_nxt = '0;
        end else if (uc_cnt == TRIP_LAST) begin
          expire = 1'b1;
          uc_nxt = '0;
          ok_nxt = '0;
        end else begin
          uc_nxt = uc_cnt + 1'b1;
          ok_nxt = ok_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_cnt <= '0;
      ok_cnt <= '0;
    end else begin
      uc_cnt <= uc_nxt;
      ok_cnt <= ok_nxt;
    end
  end
endmodule

// File: rtl/zcpg_fault_latch.sv
module zcpg_fault_latch
  import zcpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic det_off,
  input  logic det_ok,
  input  logic expire,
  output logic latched,
  output logic disc_req
);
  rel_src_t rel;

  always_comb begin
    if (!en)                   rel = REL_ENABLE;
    else if (det_ok && !det_off) rel = REL_DETECT;
    else                       rel = REL_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= 1'b0;
      disc_req <= 1'b0;
    end else begin
      disc_req <= expire;
      if (rel != REL_HOLD) latched <= 1'b0;
      else if (expire)     latched <= 1'b1;
    end
  end
endmodule

// File: rtl/zcpg_monitor.sv
module zcpg_monitor #(
  parameter int PG_ON_TICKS  = 880,
  parameter int PG_OFF_TICKS = 14,
  parameter int TRIP_TICKS   = 3500,
  parameter int GLITCH_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic near_in,
  input  logic out_drop,
  input  logic under_i,
  input  logic zc_en,
  input  logic det_off,
  input  logic det_ok,
  output logic pgood,
  output logic zc_n,
  output logic disc_req
);
  logic armed;
  logic expire;
  logic latched;

  zcpg_pg_filter #(.ON_TICKS(PG_ON_TICKS), .OFF_TICKS(PG_OFF_TICKS)) pg_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .near_in(near_in), .out_drop(out_drop), .pgood(pgood)
  );

  assign armed = en & zc_en & pgood & ~latched;

  zcpg_uc_timer #(.TRIP_TICKS(TRIP_TICKS), .GLITCH_TICKS(GLITCH_TICKS)) uc_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .armed(armed),
    .under_i(under_i), .expire(expire)
  );

  zcpg_fault_latch lat_i (
    .clk(clk), .rst_n(rst_n), .en(en), .det_off(det_off), .det_ok(det_ok),
    .expire(expire), .latched(latched), .disc_req(disc_req)
  );

  assign zc_n = ~latched;
endmodule

// File: rtl/zcpg_monitor_chk.sv
module zcpg_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic near_in,
  input logic out_drop,
  input logic zc_en,
  input logic det_off,
  input logic det_ok,
  input logic pgood,
  input logic zc_n,
  input logic disc_req
);
  a_r1_rise_needs_near: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(near_in));
  a_r2_fall_needs_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood) |-> $past(out_drop));
  a_r3_fault_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disc_req) |-> $past(zc_en && pgood && en));
  a_r6_zc_falls_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zc_n) |-> disc_req);
  a_r6_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req |=> !disc_req);
  a_r7_r8_release_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zc_n) |-> ($past(!en) || $past(det_ok && !det_off)));
endmodule

bind zcpg_monitor zcpg_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .near_in(near_in), .out_drop(out_drop),
  .zc_en(zc_en), .det_off(det_off), .det_ok(det_ok),
  .pgood(pgood), .zc_n(zc_n), .disc_req(disc_req)
);

// File: tb/zcpg_monitor_tb.sv
module zcpg_monitor_tb_top;
  localparam int PG_ON = 8, PG_OFF = 3, TRIP = 20, GL = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, en = 1'b0;
  logic near_in = 1'b0, out_drop = 1'b0, under_i = 1'b0;
  logic zc_en = 1'b0, det_off = 1'b0, det_ok = 1'b0;
  logic pgood, zc_n, disc_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  zcpg_monitor #(.PG_ON_TICKS(PG_ON), .PG_OFF_TICKS(PG_OFF),
                 .TRIP_TICKS(TRIP), .GLITCH_TICKS(GL)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .near_in(near_in),
    .out_drop(out_drop), .under_i(under_i), .zc_en(zc_en), .det_off(det_off),
    .det_ok(det_ok), .pgood(pgood), .zc_n(zc_n), .disc_req(disc_req)
  );

  typedef struct packed {
    logic near, drop, under, zen, doff, dok, en;
    logic [7:0] n;
    logic pg, zcn, disc;
  } vec_t;

  // Scenario rows, applied in order with tick high every clock.
  localparam vec_t VEC [31] = '{
    '{1,0,0,0,0,0,1,  7, 0,1,0},  // 0  R1 one tick short
    '{1,0,0,0,0,0,1,  1, 1,1,0},  // 1  R1 rise
    '{1,0,1,1,0,0,1, 19, 1,1,0},  // 2  R4 one short of trip
    '{1,0,1,1,0,0,1,  1, 1,0,1},  // 3  R4 R6 trip
    '{1,0,1,1,0,0,1,  1, 1,0,0},  // 4  R6 single pulse, still latched
    '{1,0,1,1,0,1,1,  1, 1,1,0},  // 5  R7 detection releases
    '{1,0,0,1,0,0,1,  2, 1,1,0},  // 6  idle
    '{1,0,1,1,0,0,1,  5, 1,1,0},  // 7  R5 interval start
    '{1,0,0,1,0,0,1,  3, 1,1,0},  // 8  R5 short above-threshold
    '{1,0,1,1,0,0,1, 11, 1,1,0},  // 9  R5 total 19
    '{1,0,1,1,0,0,1,  1, 1,0,1},  // 10 R5 timer ran through glitch
    '{1,0,0,1,0,1,1,  1, 1,1,0},  // 11 R7 release
    '{1,0,1,1,0,0,1,  5, 1,1,0},  // 12 R5
    '{1,0,0,1,0,0,1,  4, 1,1,0},  // 13 R5 full window resets timer
    '{1,0,1,1,0,0,1, 19, 1,1,0},  // 14 R5 fresh count
    '{1,0,1,1,0,0,1,  1, 1,0,1},  // 15 R4 trip
    '{1,0,0,1,1,1,1,  1, 1,0,0},  // 16 R8 det_ok ignored
    '{1,0,0,1,1,0,1,  3, 1,0,0},  // 17 R8 stays latched
    '{1,0,0,1,1,0,0,  1, 1,1,0},  // 18 R8 en low releases
    '{1,0,0,1,0,0,1,  1, 1,1,0},  // 19
    '{1,0,1,0,0,0,1, 30, 1,1,0},  // 20 R3 zc_en low: no fault
    '{1,0,1,1,0,0,1, 10, 1,1,0},  // 21 R9 timer part way
    '{0,1,1,1,0,0,1,  2, 1,1,0},  // 22 R2 one short
    '{0,1,1,1,0,0,1,  1, 0,1,0},  // 23 R2 fall
    '{1,0,1,1,0,0,1,  8, 1,1,0},  // 24 R1 R3 back up, not armed while low
    '{1,0,1,1,0,0,1, 19, 1,1,0},  // 25 R9 timer started from zero
    '{1,0,1,1,0,0,1,  1, 1,0,1},  // 26 R9 trip after full interval
    '{1,0,0,1,0,1,1,  1, 1,1,0},  // 27 R7
    '{0,1,0,1,0,0,1,  2, 1,1,0},  // 28 R2 short drop
    '{1,0,0,1,0,0,1,  1, 1,1,0},  // 29 R2 drop ends, count restarts
    '{0,1,0,1,0,0,1,  2, 1,1,0}   // 30 R2 still high
  };

  task automatic check(input string tag, input logic pg_e, zcn_e, disc_e);
    checks++;
    if (pgood !== pg_e || zc_n !== zcn_e || disc_req !== disc_e) begin
      errors++;
      $display("FAIL %s: got pg=%b zc_n=%b disc=%b, expected pg=%b zc_n=%b disc=%b",
               tag, pgood, zc_n, disc_req, pg_e, zcn_e, disc_e);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R10 reset state", 0, 1, 0);
    rst_n = 1'b1;
    en = 1'b1;
    near_in = 1'b1;
    step(20);
    check("R10 no tick no count", 0, 1, 0);
    tick = 1'b1;
    for (int i = 0; i < 31; i++) begin
      near_in  = VEC[i].near;
      out_drop = VEC[i].drop;
      under_i  = VEC[i].under;
      zc_en    = VEC[i].zen;
      det_off  = VEC[i].doff;
      det_ok   = VEC[i].dok;
      en       = VEC[i].en;
      if (VEC[i].dok) begin
        step(1);
        det_ok = 1'b0;
        step(int'(VEC[i].n) - 1);
      end else begin
        step(int'(VEC[i].n));
      end
      check($sformatf("row %0d", i), VEC[i].pg, VEC[i].zcn, VEC[i].disc);
    end
    // R1: near_in dropping before qualification restarts the count
    near_in = 1'b0; out_drop = 1'b1; under_i = 1'b0;
    step(3);
    check("R2 fall", 0, 1, 0);
    out_drop = 1'b0; near_in = 1'b1;
    step(5);
    near_in = 1'b0;
    step(1);
    near_in = 1'b1;
    step(7);
    check("R1 restart one short", 0, 1, 0);
    step(1);
    check("R1 restart rise", 1, 1, 0);
    // R10: reset mid-operation
    rst_n = 1'b0;
    step(1);
    check("R10 reset again", 0, 1, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule